// File: doc/BRIEF.md
# Streaming Colour Blob Labeler

This block sits inline in a pixel stream on its way from a camera-like source to frame storage. Every pixel is forwarded unchanged one cycle later. At the same time each pixel is tested against a programmable colour window given as a lower and upper bound for each of the three RGB565 channels. Matching pixels are grouped into 4-connected regions by a one-pass raster labeller. The labeller keeps only a single row of labels and a flat parent table. When two regions meet, the higher-numbered label is folded into the lower one in the same pixel time. Its pixel count and coordinate sums are added into the survivor at that moment, so no second pass over the frame is needed.

When the frame's last pixel has been seen, the block picks the region with the largest pixel count. It divides the coordinate sums of that region by its count to get a centroid. It then reports the label, the area, the centroid and an overflow flag as a one-cycle result pulse. All per-frame state is cleared for the next frame. The next frame's first pixel must arrive at least two cycles after the previous last pixel.

Top module: `blob_labeler`

## Requirements
- R1: `out_valid`, `out_data`, `out_sof`, `out_eol` and `out_eof` equal the corresponding pixel inputs one clock later. Cycles with `pix_valid` low do not advance the column or row position.
- R2: A pixel counts as object when red (`pix_data[15:11]`), green (`pix_data[10:5]`) and blue (`pix_data[4:0]`) each lie within their inclusive lower and upper threshold. All other pixels are background.
- R3: Object pixels are joined only through their left or upper neighbour. Two regions that touch only diagonally are separate.
- R4: Regions that first appear apart and later meet are reported as one region with the full combined pixel count. This holds for U-shapes and for chains of several merges.
- R5: Labels are issued from 1 upward, one per object pixel whose left and upper neighbours are both background or outside the frame. A merged region keeps the smaller of the two labels, and that label is the one reported.
- R6: `res_area` is the pixel count of the largest region. On equal counts the smaller label wins.
- R7: `res_cx` and `res_cy` are the floor of the x and y coordinate sums divided by `res_area`, with the origin at the first pixel of the frame. Both are 0 when the frame holds no object pixel.
- R8: At most NLAB-1 labels exist per frame. An object pixel that would need a new label after that is not counted, and `res_overflow` is set in that frame's result only.
- R9: After the frame's last pixel, `res_valid` pulses for one cycle within SW+4 cycles. The result fields hold until the next pulse. The next frame starts from empty accumulators, with label numbering restarted.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 16 | RGB565 pixel |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a row |
| pix_eof | input | 1 | Last pixel of a frame |
| thr_r_lo | input | 5 | Red lower bound |
| thr_r_hi | input | 5 | Red upper bound |
| thr_g_lo | input | 6 | Green lower bound |
| thr_g_hi | input | 6 | Green upper bound |
| thr_b_lo | input | 5 | Blue lower bound |
| thr_b_hi | input | 5 | Blue upper bound |
| out_valid | output | 1 | Forwarded valid |
| out_data | output | 16 | Forwarded pixel |
| out_sof | output | 1 | Forwarded start-of-frame |
| out_eol | output | 1 | Forwarded end-of-row |
| out_eof | output | 1 | Forwarded end-of-frame |
| res_valid | output | 1 | One-cycle result strobe |
| res_label | output | clog2(NLAB) | Label of largest region |
| res_area | output | clog2(MAX_W)+clog2(MAX_H) | Its pixel count |
| res_cx | output | clog2(MAX_W) | Centroid column |
| res_cy | output | clog2(MAX_H) | Centroid row |
| res_overflow | output | 1 | Label supply ran out this frame |

## Verification
The bench builds the block with MAX_W and MAX_H of 32 and the default NLAB of 64. This keeps the row buffer and the coordinate widths small while leaving the full label table in place. A 16 by 16 frame of isolated dots therefore needs exactly one label more than the table holds, which brings the exhaustion path within reach in a short run. Frames of 16 by 12 and smaller carry rectangles, U-shapes, a triple merge chain, diagonal contact and a tie. Idle cycles are inserted between pixels, and the results are compared against a flood-fill model in the bench.

// File: rtl/blob_pkg.sv
package blob_pkg;

  typedef struct packed {
    logic [4:0] r;
    logic [5:0] g;
    logic [4:0] b;
  } rgb565_t;

  // inclusive window test, channels zero-extended to 8 bits
  function automatic logic in_band(input logic [7:0] v, input logic [7:0] lo,
                                   input logic [7:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic logic [7:0] lab_lo(input logic [7:0] a, input logic [7:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [7:0] lab_hi(input logic [7:0] a, input logic [7:0] b);
    return (a < b) ? b : a;
  endfunction

endpackage

// File: rtl/blob_classify.sv
module blob_classify
  import blob_pkg::*;
(
  input  logic [15:0] pix,
  input  logic [4:0]  r_lo,
  input  logic [4:0]  r_hi,
  input  logic [5:0]  g_lo,
  input  logic [5:0]  g_hi,
  input  logic [4:0]  b_lo,
  input  logic [4:0]  b_hi,
  output logic        hit
);
  rgb565_t c;
  logic r_ok, g_ok, b_ok;

  always_comb begin
    c    = rgb565_t'(pix);
    r_ok = in_band(8'(c.r), 8'(r_lo), 8'(r_hi));
    g_ok = in_band(8'(c.g), 8'(g_lo), 8'(g_hi));
    b_ok = in_band(8'(c.b), 8'(b_lo), 8'(b_hi));
    hit  = r_ok && g_ok && b_ok;
  end
endmodule

// File: rtl/blob_linebuf.sv
module blob_linebuf #(
  parameter int DEPTH = 640,
  parameter int AW    = 10,
  parameter int DW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/blob_divider.sv
// Restoring divider: one quotient bit per cycle, zero divisor gives zero.
module blob_divider #(
  parameter int NW = 29,
  parameter int DW = 19,
  parameter int QW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [QW-1:0] quo
);
  localparam int CNTW = $clog2(NW + 1);

  logic [NW-1:0]   q_r;
  logic [DW:0]     r_r;
  logic [DW-1:0]   d_r;
  logic [CNTW-1:0] cnt;
  logic            busy, dz;
  logic [DW:0]     shifted, diff;
  logic            ge;

  always_comb begin
    shifted = {r_r[DW-1:0], q_r[NW-1]};
    ge      = shifted >= {1'b0, d_r};
    diff    = shifted - {1'b0, d_r};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r <= '0; r_r <= '0; d_r <= '0; cnt <= '0;
      busy <= 1'b0; dz <= 1'b0; done <= 1'b0;
    end else if (start) begin
      q_r  <= num;
      r_r  <= '0;
      d_r  <= den;
      dz   <= (den == '0);
      cnt  <= CNTW'(NW);
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy) begin
      r_r  <= ge ? diff : shifted;
      q_r  <= {q_r[NW-2:0], ge};
      cnt  <= cnt - 1'b1;
      busy <= (cnt != CNTW'(1));
      done <= (cnt == CNTW'(1));
    end else begin
      done <= 1'b0;
    end
  end

  assign quo = dz ? '0 : q_r[QW-1:0];
endmodule

// File: rtl/blob_labeler.sv
module blob_labeler
  import blob_pkg::*;
#(
  parameter int MAX_W = 640,
  parameter int MAX_H = 480,
  parameter int NLAB  = 64,
  localparam int XW = $clog2(MAX_W),
  localparam int YW = $clog2(MAX_H),
  localparam int LW = $clog2(NLAB),
  localparam int AW = XW + YW,
  localparam int CW = (XW > YW) ? XW : YW,
  localparam int SW = AW + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic [15:0]   pix_data,
  input  logic          pix_sof,
  input  logic          pix_eol,
  input  logic          pix_eof,
  input  logic [4:0]    thr_r_lo,
  input  logic [4:0]    thr_r_hi,
  input  logic [5:0]    thr_g_lo,
  input  logic [5:0]    thr_g_hi,
  input  logic [4:0]    thr_b_lo,
  input  logic [4:0]    thr_b_hi,
  output logic          out_valid,
  output logic [15:0]   out_data,
  output logic          out_sof,
  output logic          out_eol,
  output logic          out_eof,
  output logic          res_valid,
  output logic [LW-1:0] res_label,
  output logic [AW-1:0] res_area,
  output logic [XW-1:0] res_cx,
  output logic [YW-1:0] res_cy,
  output logic          res_overflow
);
  localparam logic [LW:0] LAB_CAP = (LW+1)'(NLAB);

  // position
  logic [XW-1:0] x_cnt, cur_x;
  logic [YW-1:0] y_cnt, cur_y;

  // labelling state
  logic [LW-1:0] parent [NLAB];
  logic [AW-1:0] area   [NLAB];
  logic [SW-1:0] sumx   [NLAB];
  logic [SW-1:0] sumy   [NLAB];
  logic [LW-1:0] left_lab, lb_rd;
  logic [LW:0]   lab_next;
  logic          ovf_flag;
  logic          eof_q;

  // named events for the checker
  logic          is_obj, new_req, new_grant, lab_exhausted, merge_evt;
  logic [LW-1:0] lft, up_lab, lab, keep_lab, kill_lab;
  logic [AW-1:0] upd_area;
  logic [SW-1:0] upd_sx, upd_sy;

  // result selection
  logic [LW-1:0] best_lab, pend_lab;
  logic [AW-1:0] best_area, pend_area;
  logic          pend_ovf;
  logic [SW-1:0] dv_num [2];
  logic [CW-1:0] dv_q   [2];
  logic [1:0]    dv_done;

  // ---------------- pass-through ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0;
      out_sof <= 1'b0; out_eol <= 1'b0; out_eof <= 1'b0;
    end else begin
      out_valid <= pix_valid;
      out_data  <= pix_data;
      out_sof   <= pix_sof;
      out_eol   <= pix_eol;
      out_eof   <= pix_eof;
    end
  end

  // ---------------- classification ----------------
  blob_classify cls_i (
    .pix(pix_data), .r_lo(thr_r_lo), .r_hi(thr_r_hi), .g_lo(thr_g_lo),
    .g_hi(thr_g_hi), .b_lo(thr_b_lo), .b_hi(thr_b_hi), .hit(is_obj)
  );

  assign cur_x = pix_sof ? '0 : x_cnt;
  assign cur_y = pix_sof ? '0 : y_cnt;

  blob_linebuf #(.DEPTH(MAX_W), .AW(XW), .DW(LW)) lb_i (
    .clk(clk), .we(pix_valid), .waddr(cur_x), .wdata(lab),
    .raddr(cur_x), .rdata(lb_rd)
  );

  // ---------------- label decision ----------------
  always_comb begin
    lft           = (cur_x != '0) ? left_lab : '0;
    up_lab        = (cur_y != '0) ? parent[lb_rd] : '0;
    lab_exhausted = (lab_next == LAB_CAP);
    new_req       = 1'b0;
    merge_evt     = 1'b0;
    lab           = '0;
    keep_lab      = '0;
    kill_lab      = '0;
    if (pix_valid && is_obj) begin
      if (lft == '0 && up_lab == '0) begin
        new_req = 1'b1;
        lab     = lab_exhausted ? '0 : lab_next[LW-1:0];
      end else if (lft == '0) begin
        lab = up_lab;
      end else if (up_lab == '0 || up_lab == lft) begin
        lab = lft;
      end else begin
        merge_evt = 1'b1;
        keep_lab  = LW'(lab_lo(8'(lft), 8'(up_lab)));
        kill_lab  = LW'(lab_hi(8'(lft), 8'(up_lab)));
        lab       = keep_lab;
      end
    end
    new_grant = new_req && !lab_exhausted;
    upd_area  = area[lab] + (merge_evt ? area[kill_lab] : '0) + AW'(1);
    upd_sx    = sumx[lab] + (merge_evt ? sumx[kill_lab] : '0) + SW'(cur_x);
    upd_sy    = sumy[lab] + (merge_evt ? sumy[kill_lab] : '0) + SW'(cur_y);
  end

  // ---------------- labelling state ----------------
  always_ff @(posedge clk) begin
    if (!rst_n || eof_q) begin
      if (!rst_n) begin
        x_cnt <= '0; y_cnt <= '0; left_lab <= '0;
      end
      lab_next <= (LW+1)'(1);
      ovf_flag <= 1'b0;
      for (int i = 0; i < NLAB; i++) begin
        parent[i] <= LW'(i);
        area[i]   <= '0;
        sumx[i]   <= '0;
        sumy[i]   <= '0;
      end
    end else if (pix_valid) begin
      x_cnt    <= pix_eol ? '0 : cur_x + XW'(1);
      y_cnt    <= pix_eol ? cur_y + YW'(1) : cur_y;
      left_lab <= lab;
      if (new_grant) lab_next <= lab_next + 1'b1;
      if (new_req && lab_exhausted) ovf_flag <= 1'b1;
      if (merge_evt) begin
        area[kill_lab] <= '0;
        sumx[kill_lab] <= '0;
        sumy[kill_lab] <= '0;
        for (int i = 0; i < NLAB; i++)
          if (parent[i] == kill_lab) parent[i] <= keep_lab;
      end
      if (lab != '0) begin
        area[lab] <= upd_area;
        sumx[lab] <= upd_sx;
        sumy[lab] <= upd_sy;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) eof_q <= 1'b0;
    else        eof_q <= pix_valid && pix_eof;
  end

  // ---------------- largest region ----------------
  always_comb begin
    best_lab  = '0;
    best_area = '0;
    for (int i = 1; i < NLAB; i++) begin
      if (area[i] > best_area) begin
        best_area = area[i];
        best_lab  = LW'(i);
      end
    end
    dv_num[0] = sumx[best_lab];
    dv_num[1] = sumy[best_lab];
  end

  for (genvar a = 0; a < 2; a++) begin : g_axis
    blob_divider #(.NW(SW), .DW(AW), .QW(CW)) div_i (
      .clk(clk), .rst_n(rst_n), .start(eof_q), .num(dv_num[a]),
      .den(best_area), .done(dv_done[a]), .quo(dv_q[a])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_lab <= '0; pend_area <= '0; pend_ovf <= 1'b0;
      res_valid <= 1'b0; res_label <= '0; res_area <= '0;
      res_cx <= '0; res_cy <= '0; res_overflow <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (eof_q) begin
        pend_lab  <= best_lab;
        pend_area <= best_area;
        pend_ovf  <= ovf_flag;
      end
      if (&dv_done) begin
        res_valid    <= 1'b1;
        res_label    <= pend_lab;
        res_area     <= pend_area;
        res_overflow <= pend_ovf;
        res_cx       <= dv_q[0][XW-1:0];
        res_cy       <= dv_q[1][YW-1:0];
      end
    end
  end
endmodule

// File: rtl/blob_labeler_chk.sv
module blob_labeler_chk #(
  parameter int NLAB = 64,
  parameter int LW   = 6,
  parameter int AW   = 19,
  parameter int XW   = 10,
  parameter int YW   = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_valid,
  input logic [15:0]   pix_data,
  input logic          out_valid,
  input logic [15:0]   out_data,
  input logic          res_valid,
  input logic [AW-1:0] res_area,
  input logic [XW-1:0] res_cx,
  input logic [YW-1:0] res_cy,
  input logic [LW:0]   lab_next,
  input logic          new_req,
  input logic          lab_exhausted,
  input logic          ovf_flag
);
  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> (out_valid && out_data == $past(pix_data)));

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  assert_res_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_res_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_area));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lab_next <= (LW+1)'(NLAB));

  assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && new_req && lab_exhausted) |=> ovf_flag);

  assert_empty_centroid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_area == '0) |-> (res_cx == '0 && res_cy == '0));
endmodule

bind blob_labeler blob_labeler_chk #(
  .NLAB(NLAB), .LW(LW), .AW(AW), .XW(XW), .YW(YW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
  .out_valid(out_valid), .out_data(out_data), .res_valid(res_valid),
  .res_area(res_area), .res_cx(res_cx), .res_cy(res_cy),
  .lab_next(lab_next), .new_req(new_req), .lab_exhausted(lab_exhausted),
  .ovf_flag(ovf_flag)
);

// File: tb/blob_labeler_tb_top.sv
`timescale 1ns/1ps
module blob_labeler_tb_top;
  localparam int MW = 32, MH = 32, NL = 64;
  localparam int XW = $clog2(MW), YW = $clog2(MH), LW = $clog2(NL), AW = XW + YW;

  typedef struct packed {
    logic [7:0] w, h, fr, fgc, fb, br, bgc, bb;
    logic [3:0][31:0] rc;   // x0,y0,x1,y1 bytes; x0>x1 means unused
    logic [15:0] ea;        // expected area
  } frame_t;

  localparam logic [31:0] E = 32'h01000000;
  localparam frame_t TBL [8] = '{
    '{8'd16, 8'd12, 8'd15, 8'd30, 8'd10, 8'd21, 8'd30, 8'd10, {E, E, E, 32'h02030605}, 16'd15},
    '{8'd16, 8'd12, 8'd10, 8'd40, 8'd15, 8'd9,  8'd30, 8'd10, {E, 32'h0109080A, 32'h07010808, 32'h01010208}, 16'd48},
    '{8'd16, 8'd12, 8'd20, 8'd20, 8'd5,  8'd15, 8'd19, 8'd10, {E, E, 32'h05040C09, 32'h00000201}, 16'd48},
    '{8'd16, 8'd12, 8'd12, 8'd25, 8'd7,  8'd15, 8'd41, 8'd10, {32'h01070707, 32'h07000706, 32'h04000406, 32'h01000106}, 16'd28},
    '{8'd14, 8'd9,  8'd15, 8'd30, 8'd10, 8'd15, 8'd30, 8'd4,  {E, E, 32'h02060307, 32'h0A010B02}, 16'd4},
    '{8'd16, 8'd12, 8'd15, 8'd30, 8'd10, 8'd15, 8'd30, 8'd16, {E, E, E, E}, 16'd0},
    '{8'd16, 8'd12, 8'd18, 8'd33, 8'd9,  8'd0,  8'd0,  8'd0,  {E, 32'h00040904, 32'h03000903, 32'h00000105}, 16'd48},
    '{8'd10, 8'd8,  8'd15, 8'd30, 8'd10, 8'd31, 8'd63, 8'd31, {E, E, 32'h04040606, 32'h02020303}, 16'd9}
  };

  logic clk = 1'b0, rst_n;
  logic pix_valid, pix_sof, pix_eol, pix_eof;
  logic [15:0] pix_data;
  logic [4:0] thr_r_lo, thr_r_hi, thr_b_lo, thr_b_hi;
  logic [5:0] thr_g_lo, thr_g_hi;
  logic out_valid, out_sof, out_eol, out_eof, res_valid, res_overflow;
  logic [15:0] out_data;
  logic [LW-1:0] res_label;
  logic [AW-1:0] res_area;
  logic [XW-1:0] res_cx;
  logic [YW-1:0] res_cy;

  always #2.5 clk = ~clk;

  blob_labeler #(.MAX_W(MW), .MAX_H(MH), .NLAB(NL)) dut_i (.*);

  int n_chk = 0, n_fail = 0, pass_mis = 0;
  bit bm [MH][MW];
  int fw, fh;
  logic [15:0] fg_px, bg_px;
  int exp_lab, exp_area, exp_cx, exp_cy, exp_ovf;
  int got_lab, got_area, got_cx, got_cy, got_ovf, got;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pass-through monitor (R1)
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (out_valid !== pix_valid) pass_mis++;
      else if (pix_valid && (out_data !== pix_data || out_sof !== pix_sof ||
               out_eol !== pix_eol || out_eof !== pix_eof)) pass_mis++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual=hung expected=result");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  function automatic logic [15:0] rgb(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    return {r[4:0], g[5:0], b[4:0]};
  endfunction

  task automatic load_table(input int t);
    frame_t f = TBL[t];
    fw = f.w; fh = f.h;
    fg_px = rgb(f.fr, f.fgc, f.fb);
    bg_px = rgb(f.br, f.bgc, f.bb);
    for (int y = 0; y < MH; y++) for (int x = 0; x < MW; x++) bm[y][x] = 1'b0;
    for (int k = 0; k < 4; k++)
      for (int y = int'(f.rc[k][23:16]); y <= int'(f.rc[k][7:0]); y++)
        for (int x = int'(f.rc[k][31:24]); x <= int'(f.rc[k][15:8]); x++)
          bm[y][x] = 1'b1;
  endtask

  task automatic load_dots();
    fw = 16; fh = 16;
    fg_px = rgb(8'd15, 8'd30, 8'd10);
    bg_px = 16'h0000;
    for (int y = 0; y < MH; y++) for (int x = 0; x < MW; x++)
      bm[y][x] = (y < 16 && x < 16 && x % 2 == 0 && y % 2 == 0);
  endtask

  // flood-fill reference: component id = first raster index + 1
  task automatic model();
    int comp [MH][MW];
    int ar [MH*MW];
    longint sx [MH*MW], sy [MH*MW];
    int seeds, best_a, best_i, lbl;
    bit chg;
    for (int y = 0; y < fh; y++) for (int x = 0; x < fw; x++)
      comp[y][x] = bm[y][x] ? y*fw + x + 1 : 0;
    chg = 1'b1;
    while (chg) begin
      chg = 1'b0;
      for (int y = 0; y < fh; y++) for (int x = 0; x < fw; x++) if (bm[y][x]) begin
        if (x > 0 && bm[y][x-1] && comp[y][x-1] < comp[y][x]) begin comp[y][x] = comp[y][x-1]; chg = 1'b1; end
        if (y > 0 && bm[y-1][x] && comp[y-1][x] < comp[y][x]) begin comp[y][x] = comp[y-1][x]; chg = 1'b1; end
        if (x < fw-1 && bm[y][x+1] && comp[y][x+1] < comp[y][x]) begin comp[y][x] = comp[y][x+1]; chg = 1'b1; end
        if (y < fh-1 && bm[y+1][x] && comp[y+1][x] < comp[y][x]) begin comp[y][x] = comp[y+1][x]; chg = 1'b1; end
      end
    end
    for (int i = 0; i < MH*MW; i++) begin ar[i] = 0; sx[i] = 0; sy[i] = 0; end
    for (int y = 0; y < fh; y++) for (int x = 0; x < fw; x++) if (bm[y][x]) begin
      ar[comp[y][x]-1]++; sx[comp[y][x]-1] += x; sy[comp[y][x]-1] += y;
    end
    seeds = 0; best_a = 0; best_i = -1; lbl = 0; exp_ovf = 0; exp_lab = 0;
    for (int y = 0; y < fh; y++) for (int x = 0; x < fw; x++) begin
      if (bm[y][x] && (x == 0 || !bm[y][x-1]) && (y == 0 || !bm[y-1][x])) begin
        seeds++;
        if (seeds > NL-1) exp_ovf = 1;
        else if (comp[y][x] == y*fw + x + 1 && ar[y*fw+x] > best_a) begin
          best_a = ar[y*fw+x]; best_i = y*fw + x; exp_lab = seeds;
        end
      end
    end
    exp_area = best_a;
    exp_cx = (best_i >= 0) ? int'(sx[best_i] / best_a) : 0;
    exp_cy = (best_i >= 0) ? int'(sy[best_i] / best_a) : 0;
  endtask

  task automatic run_frame();
    int base = pass_mis;
    for (int y = 0; y < fh; y++) for (int x = 0; x < fw; x++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data  = bm[y][x] ? fg_px : bg_px;
      pix_sof   = (x == 0 && y == 0);
      pix_eol   = (x == fw-1);
      pix_eof   = (x == fw-1 && y == fh-1);
      if ((x + 2*y) % 7 == 3) begin
        @(negedge clk);
        pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0; pix_eof = 1'b0;
      end
    end
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0; pix_eof = 1'b0;
    got = 0;
    for (int k = 0; k < 60 && got == 0; k++) begin
      @(posedge clk); #1;
      if (res_valid) begin
        got = 1; got_lab = res_label; got_area = res_area;
        got_cx = res_cx; got_cy = res_cy; got_ovf = res_overflow;
      end
    end
    check(got == 1, "R9 result strobe", got, 1);
    check(pass_mis == base, "R1 pass-through mismatches", pass_mis - base, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_result(input string tag);
    check(got_area == exp_area, {tag, " R6/R4/R3/R2 area"}, got_area, exp_area);
    check(got_lab == exp_lab, {tag, " R5 label"}, got_lab, exp_lab);
    check(got_cx == exp_cx, {tag, " R7 cx"}, got_cx, exp_cx);
    check(got_cy == exp_cy, {tag, " R7 cy"}, got_cy, exp_cy);
    check(got_ovf == exp_ovf, {tag, " R8 overflow"}, got_ovf, exp_ovf);
  endtask

  initial begin
    rst_n = 1'b0;
    pix_valid = 1'b0; pix_data = '0; pix_sof = 1'b0; pix_eol = 1'b0; pix_eof = 1'b0;
    thr_r_lo = 5'd10; thr_r_hi = 5'd20;
    thr_g_lo = 6'd20; thr_g_hi = 6'd40;
    thr_b_lo = 5'd5;  thr_b_hi = 5'd15;
    repeat (4) @(posedge clk);
    #1;
    // R10: reset state
    check(out_valid == 0 && res_valid == 0 && res_area == 0 && res_label == 0 &&
          res_cx == 0 && res_cy == 0 && res_overflow == 0 && out_data == 0,
          "R10 reset outputs", int'(res_area) + int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: shapes, merges, diagonal, tie, empty, colour windows
    for (int t = 0; t < 8; t++) begin
      load_table(t);
      model();
      check(exp_area == int'(TBL[t].ea), "R6 model area vs table", exp_area, int'(TBL[t].ea));
      run_frame();
      check_result($sformatf("frame%0d", t));
    end

    // R8: label exhaustion with 64 isolated dots
    load_dots();
    model();
    run_frame();
    check_result("dots");
    check(exp_ovf == 1, "R8 dot frame overflows", exp_ovf, 1);

    // R8/R9: next frame starts clean
    load_table(0);
    model();
    run_frame();
    check_result("after_ovf");

    // R9: result held after the pulse
    repeat (6) @(negedge clk);
    check(int'(res_area) == 15 && res_valid == 0, "R9 result held", int'(res_area), 15);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule